// File: doc/BRIEF.md
# Infrared Pulse-Width Bit Decoder

This block recovers data words from a demodulated infrared receiver line. The line idles high and pulls low for each mark. The decoder times every mark in units of a slow tick, nominally 0.1 ms, which it derives from the system clock. From the length of each mark it decides whether the mark opens a frame, carries a one, carries a zero, or is invalid.

A frame opens with a long lead mark of about 2.5 ms. Each later mark is read as a one (about 1.2 ms) or a zero (about 0.6 ms) and is written into the word, first bit received at bit 0. The frame closes once the set number of bits has arrived, or earlier if the line stays quiet for too long after at least one bit. At that point the word is presented together with a one-cycle strobe. A mark of any other length raises a one-cycle error pulse and drops the partial frame.

The receiver line is treated as asynchronous and passes through a two-flop synchroniser. Carrier removal and the meaning of fields inside the word are left to other logic.

Top module: `ir_pw_decoder`

## Requirements
- R1: The decoder counts time in ticks of CLK_PER_TICK clock cycles (default 5000, which is 0.1 ms at 50 MHz). The tick counter runs from 0 to CLK_PER_TICK-1 and strobes on its wrap cycle.
- R2: Only a first mark of 22 to 28 ticks, inclusive, opens a frame. A first mark of any other width pulses frame_err for one cycle and the decoder goes back to waiting.
- R3: Inside a frame, a mark of 10 to 15 ticks is a one and a mark of 4 to 8 ticks is a zero. The n-th data mark received is written to data_out bit n-1, so bit 0 holds the first data bit.
- R4: Inside a frame, a mark outside both data windows pulses frame_err for one cycle and discards the frame, so no frame_valid follows for it. frame_err and frame_valid are never high in the same cycle.
- R5: When NUM_BITS data marks have been accepted (default 12), frame_valid is high for exactly one cycle. From that cycle on, data_out holds the word, and it changes only in a cycle where frame_valid is high.
- R6: If at least one bit has been received and the line then stays high for more than 40 ticks, the frame closes with frame_valid. Bits that were not received read as 0. A high gap of exactly 40 ticks does not close the frame.
- R7: Mark width is counted up to a ceiling of 63 ticks and holds there. A mark of 74 ticks inside a frame is rejected with frame_err and is not wrapped into the one window.
- R8: Synchronous reset clears data_out, frame_valid, frame_err and any partial frame. Marks that follow a reset taken mid-frame are not treated as data bits.
- R9: rx_n is active-low (a mark is a low level) and may change at any time relative to clk. It is synchronised by two flops before any edge is detected.
- R10: A mark lasting exactly L×CLK_PER_TICK clock cycles measures L ticks whatever its phase relative to the tick counter. A tick that falls in the same cycle as a mark edge is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_n | input | 1 | Demodulated receiver line, low during a mark |
| data_out | output | NUM_BITS | Last completed word, first bit at bit 0 |
| frame_valid | output | 1 | One-cycle strobe when a frame completes |
| frame_err | output | 1 | One-cycle strobe when a mark width is rejected |

## Verification
Two events can land in the same clock cycle: the tick strobe and a mark edge, either where a width counter is cleared or where a finished width is classified. The bench sets up this overlap by starting each stimulus frame at a different clock phase against the tick counter. It then uses mark widths that sit exactly on the window limits (22, 28, 10, 15, 4, 8) and just outside them. A dropped or doubled tick at an edge pushes a limit width across its boundary, so the outcome is judged only from whether frame_valid or frame_err appears and from the word presented.

// File: rtl/ir_pw_pkg.sv
package ir_pw_pkg;

    localparam int WIDTH_BITS = 6;
    localparam int WIDTH_CEIL = (1 << WIDTH_BITS) - 1;

    localparam int LEAD_MIN = 22;
    localparam int LEAD_MAX = 28;
    localparam int ONE_MIN  = 10;
    localparam int ONE_MAX  = 15;
    localparam int ZERO_MIN = 4;
    localparam int ZERO_MAX = 8;
    localparam int GAP_LIMIT = 40;

    typedef logic [WIDTH_BITS-1:0] ticks_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_DONE  = 2'd3
    } ir_state_e;

    typedef enum logic [1:0] {
        MK_BAD  = 2'd0,
        MK_LEAD = 2'd1,
        MK_ONE  = 2'd2,
        MK_ZERO = 2'd3
    } mark_kind_e;

    typedef struct packed {
        logic mark_on;
        logic mark_begin;
        logic mark_end;
    } line_ev_t;

    function automatic mark_kind_e classify_mark(input ticks_t w);
        int unsigned v;
        v = int'(w);
        if (v >= LEAD_MIN && v <= LEAD_MAX)      return MK_LEAD;
        else if (v >= ONE_MIN && v <= ONE_MAX)   return MK_ONE;
        else if (v >= ZERO_MIN && v <= ZERO_MAX) return MK_ZERO;
        else                                     return MK_BAD;
    endfunction

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int CLK_PER_TICK = 5000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CLK_PER_TICK <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(CLK_PER_TICK);
            localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);
            logic [CW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst)               div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                   div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ir_line_sync.sv
module ir_line_sync
    import ir_pw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_n,
    output line_ev_t ev
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        ev.mark_on    = ~sync_q;
        ev.mark_begin = prev_q & ~sync_q;
        ev.mark_end   = ~prev_q & sync_q;
    end
endmodule

// File: rtl/ir_dur_meter.sv
module ir_dur_meter
    import ir_pw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   active,
    input  logic   tick,
    output ticks_t dur
);
    localparam ticks_t CEIL = ticks_t'(WIDTH_CEIL);
    ticks_t dur_q;

    always_ff @(posedge clk) begin
        if (rst)
            dur_q <= '0;
        else if (restart)
            dur_q <= ticks_t'(tick);
        else if (active && tick && dur_q != CEIL)
            dur_q <= dur_q + 1'b1;
    end

    assign dur = dur_q;
endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
    import ir_pw_pkg::*;
#(
    parameter int NUM_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  line_ev_t            ev,
    input  ticks_t              mark_w,
    input  ticks_t              space_w,
    output ir_state_e           state,
    output logic [NUM_BITS-1:0] word,
    output logic                valid,
    output logic                err
);
    localparam int CW = $clog2(NUM_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(NUM_BITS);

    ir_state_e           st_q, st_n;
    logic [CW-1:0]       cnt_q, cnt_n;
    logic [NUM_BITS-1:0] acc_q, acc_n;
    logic [NUM_BITS-1:0] word_q, word_n;
    logic                err_q, err_n;
    mark_kind_e          kind;
    logic                quiet_long;

    assign kind       = classify_mark(mark_w);
    assign quiet_long = !ev.mark_on && (cnt_q != '0) && (int'(space_w) > GAP_LIMIT);

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        acc_n  = acc_q;
        word_n = word_q;
        err_n  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (ev.mark_begin) st_n = ST_START;
            end
            ST_START: begin
                if (ev.mark_end) begin
                    if (kind == MK_LEAD) begin
                        st_n  = ST_DATA;
                        cnt_n = '0;
                        acc_n = '0;
                    end else begin
                        err_n = 1'b1;
                        st_n  = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (ev.mark_end) begin
                    if (kind == MK_ONE || kind == MK_ZERO) begin
                        acc_n[cnt_q] = (kind == MK_ONE);
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_n == FULL) begin
                            st_n   = ST_DONE;
                            word_n = acc_n;
                        end
                    end else begin
                        err_n = 1'b1;
                        st_n  = ST_IDLE;
                    end
                end else if (quiet_long) begin
                    st_n   = ST_DONE;
                    word_n = acc_q;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            acc_q  <= '0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            acc_q  <= acc_n;
            word_q <= word_n;
            err_q  <= err_n;
        end
    end

    assign state = st_q;
    assign word  = word_q;
    assign valid = (st_q == ST_DONE);
    assign err   = err_q;
endmodule

// File: rtl/ir_pw_decoder.sv
module ir_pw_decoder
    import ir_pw_pkg::*;
#(
    parameter int CLK_PER_TICK = 5000,
    parameter int NUM_BITS     = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_n,
    output logic [NUM_BITS-1:0] data_out,
    output logic                frame_valid,
    output logic                frame_err
);
    logic      tick;
    line_ev_t  ev;
    ticks_t    mark_w;
    ticks_t    space_w;
    ir_state_e state;

    ir_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    ir_line_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .rx_n (rx_n),
        .ev   (ev)
    );

    ir_dur_meter u_mark (
        .clk     (clk),
        .rst     (rst),
        .restart (ev.mark_begin),
        .active  (ev.mark_on),
        .tick    (tick),
        .dur     (mark_w)
    );

    ir_dur_meter u_space (
        .clk     (clk),
        .rst     (rst),
        .restart (ev.mark_end),
        .active  (~ev.mark_on),
        .tick    (tick),
        .dur     (space_w)
    );

    ir_frame_fsm #(.NUM_BITS(NUM_BITS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .mark_w  (mark_w),
        .space_w (space_w),
        .state   (state),
        .word    (data_out),
        .valid   (frame_valid),
        .err     (frame_err)
    );
endmodule

// File: rtl/ir_pw_decoder_chk.sv
module ir_pw_decoder_chk
    import ir_pw_pkg::*;
#(
    parameter int CLK_PER_TICK = 5000,
    parameter int NUM_BITS     = 12
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_BITS-1:0] data_out,
    input logic                frame_valid,
    input logic                frame_err,
    input logic                tick,
    input line_ev_t            ev,
    input ticks_t              mark_w,
    input ir_state_e           state
);
    localparam ticks_t CEIL = ticks_t'(WIDTH_CEIL);

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_err_single_r4: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && frame_err));

    p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> $stable(data_out));

    p_width_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        (mark_w == CEIL && !ev.mark_begin) |=> (mark_w == CEIL));

    p_data_after_lead_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) != ST_DATA) |-> ($past(state) == ST_START));

    generate
        if (CLK_PER_TICK > 1) begin : g_tick_chk
            p_tick_spaced_r1: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

bind ir_pw_decoder ir_pw_decoder_chk #(
    .CLK_PER_TICK (CLK_PER_TICK),
    .NUM_BITS     (NUM_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .data_out    (data_out),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .tick        (tick),
    .ev          (ev),
    .mark_w      (mark_w),
    .state       (state)
);

// File: tb/ir_pw_decoder_tb.sv
module ir_pw_decoder_tb;

    localparam int T  = 4;
    localparam int NB = 12;

    typedef struct packed {
        logic [6:0]  lead_w;
        logic [6:0]  one_w;
        logic [6:0]  zero_w;
        logic [4:0]  nbits;
        logic [11:0] data;
        logic [6:0]  gap;
        logic [2:0]  phase;
        logic        exp_valid;
        logic        exp_err;
        logic [11:0] exp_word;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{7'd25, 7'd12, 7'd6, 5'd12, 12'hA5C, 7'd6,  3'd0, 1'b1, 1'b0, 12'hA5C}, // R2 R3 R5 R9
        '{7'd22, 7'd10, 7'd4, 5'd12, 12'h3F1, 7'd6,  3'd1, 1'b1, 1'b0, 12'h3F1}, // R2 R3 R10 low limits
        '{7'd28, 7'd15, 7'd8, 5'd12, 12'hC0E, 7'd7,  3'd3, 1'b1, 1'b0, 12'hC0E}, // R2 R3 R10 high limits
        '{7'd21, 7'd12, 7'd6, 5'd12, 12'h555, 7'd6,  3'd2, 1'b0, 1'b1, 12'h000}, // R2 short lead
        '{7'd29, 7'd12, 7'd6, 5'd12, 12'h555, 7'd6,  3'd1, 1'b0, 1'b1, 12'h000}, // R2 long lead
        '{7'd25, 7'd9,  7'd6, 5'd12, 12'hFFF, 7'd6,  3'd0, 1'b0, 1'b1, 12'h000}, // R4 one short
        '{7'd25, 7'd12, 7'd3, 5'd12, 12'h000, 7'd6,  3'd2, 1'b0, 1'b1, 12'h000}, // R4 zero short
        '{7'd25, 7'd12, 7'd9, 5'd12, 12'h000, 7'd6,  3'd3, 1'b0, 1'b1, 12'h000}, // R4 between windows
        '{7'd25, 7'd16, 7'd6, 5'd12, 12'hFFF, 7'd6,  3'd1, 1'b0, 1'b1, 12'h000}, // R4 one long
        '{7'd25, 7'd12, 7'd6, 5'd5,  12'h016, 7'd6,  3'd2, 1'b1, 1'b0, 12'h016}, // R6 early close
        '{7'd25, 7'd12, 7'd6, 5'd12, 12'h5A3, 7'd40, 3'd0, 1'b1, 1'b0, 12'h5A3}  // R6 gap of 40
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_n = 1'b1;
    logic [NB-1:0] data_out;
    logic          frame_valid;
    logic          frame_err;

    int checks = 0;
    int fails  = 0;
    int valid_seen = 0;
    int err_seen   = 0;
    logic [NB-1:0] last_word = '0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    ir_pw_decoder #(.CLK_PER_TICK(T), .NUM_BITS(NB)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .rx_n        (rx_n),
        .data_out    (data_out),
        .frame_valid (frame_valid),
        .frame_err   (frame_err)
    );

    always @(negedge clk) begin
        if (!rst && frame_valid) begin
            valid_seen <= valid_seen + 1;
            last_word  <= data_out;
        end
        if (!rst && frame_err) err_seen <= err_seen + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic mark(input int ticks);
        rx_n = 1'b0;
        repeat (ticks * T) @(negedge clk);
        rx_n = 1'b1;
    endtask

    task automatic space(input int ticks);
        rx_n = 1'b1;
        repeat (ticks * T) @(negedge clk);
    endtask

    task automatic send(input vec_t v);
        idle(int'(v.phase));
        mark(int'(v.lead_w));
        space(int'(v.gap));
        for (int i = 0; i < int'(v.nbits); i++) begin
            mark(v.data[i] ? int'(v.one_w) : int'(v.zero_w));
            space(int'(v.gap));
        end
        space(60);
    endtask

    initial begin
        int v0, e0;
        vec_t dv;
        idle(5);
        rst = 1'b0;
        idle(2);
        // R8: state after reset
        check(data_out == '0, "R8 reset data_out", int'(data_out), 0);
        check(frame_valid == 1'b0, "R8 reset frame_valid", int'(frame_valid), 0);
        check(frame_err == 1'b0, "R8 reset frame_err", int'(frame_err), 0);

        for (int k = 0; k < NV; k++) begin
            v0 = valid_seen;
            e0 = err_seen;
            send(VEC[k]);
            check((valid_seen - v0) == (VEC[k].exp_valid ? 1 : 0),
                  $sformatf("R5 vec%0d valid count", k), valid_seen - v0, VEC[k].exp_valid ? 1 : 0);
            check(((err_seen - e0) != 0) == VEC[k].exp_err,
                  $sformatf("R4 vec%0d error seen", k), err_seen - e0, int'(VEC[k].exp_err));
            if (VEC[k].exp_valid)
                check(last_word == VEC[k].exp_word,
                      $sformatf("R3 vec%0d word", k), int'(last_word), int'(VEC[k].exp_word));
        end

        // R7: stuck-low mark of 74 ticks inside a frame must not wrap to a one
        v0 = valid_seen;
        e0 = err_seen;
        mark(25);
        space(6);
        mark(74);
        space(60);
        check((err_seen - e0) == 1, "R7 saturated mark rejected", err_seen - e0, 1);
        check(valid_seen == v0, "R7 no frame after saturation", valid_seen - v0, 0);

        // R8: reset taken mid-frame
        send(VEC[0]);
        check(data_out == 12'hA5C, "R8 word before reset", int'(data_out), 'hA5C);
        v0 = valid_seen;
        mark(25);
        space(6);
        for (int i = 0; i < 3; i++) begin
            mark(12);
            space(6);
        end
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        check(data_out == '0, "R8 data_out cleared mid-frame", int'(data_out), 0);
        for (int i = 0; i < 9; i++) begin
            mark(12);
            space(6);
        end
        space(60);
        check(valid_seen == v0, "R8 partial frame dropped", valid_seen - v0, 0);

        // R6 R10: early close after one bit, late phase
        dv = '{7'd24, 7'd12, 7'd6, 5'd1, 12'h001, 7'd5, 3'd3, 1'b1, 1'b0, 12'h001};
        v0 = valid_seen;
        send(dv);
        check((valid_seen - v0) == 1, "R6 single bit closes on quiet", valid_seen - v0, 1);
        check(last_word == 12'h001, "R6 single bit word", int'(last_word), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule